// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block keeps track of the operating mode of a processor core and picks the next mode whenever the core issues a sleep request. There are three running modes: active at full speed, active at reduced speed, and subactive on the slow watch clock. There are four halted modes: sleep, subsleep, watch and standby. Which mode follows a sleep request depends on five control bits. These are a standby select, a watch enable, a low-speed-on bit, a medium-speed-on bit and a direct-transfer bit. When the direct-transfer bit is set and the other bits match one of a few patterns, the core can switch directly between the two active speeds and subactive mode without passing through a halted mode.

A wake event in any halted mode sends the core back to a running mode, and the control bits choose which one. The current mode is driven as a registered one-hot vector. Bit 0 is active full speed, bit 1 is active reduced speed, bit 2 is subactive, bit 3 is sleep, bit 4 is subsleep, bit 5 is watch and bit 6 is standby. A separate combinational output gives the watch-clock divide ratio for subactive mode. It is decoded from a 2-bit select and encoded either as the ratio itself or as its base-2 logarithm. The encoding is chosen by a parameter.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the mode output is active full speed (bit 0 set, all others clear).
- R2: The mode output has exactly one bit set in every cycle.
- R3: With direct transfer off, a sleep request in either active mode leads to sleep when standby select is 0, to standby when standby select is 1 and watch enable is 0, and to watch when both are 1.
- R4: With direct transfer off, a sleep request in subactive mode leads to subsleep when standby select is 0 and to watch when standby select is 1.
- R5: With direct transfer on, a sleep request in active full speed moves to active reduced speed when standby=0, medium=1 and low=0. It moves to subactive when standby=1, watch=1 and low=1.
- R6: With direct transfer on, a sleep request in active reduced speed moves to active full speed when standby=0, medium=0 and low=0. It moves to subactive when standby=1, watch=1 and low=1.
- R7: With direct transfer on, a sleep request in subactive with standby=1, watch=1 and low=0 moves to active full speed if medium=0 and to active reduced speed if medium=1.
- R8: With direct transfer on, a sleep request whose bits match none of the patterns in R5 to R7 follows the halted-mode choice of R3 and R4.
- R9: A wake event in a halted mode moves to subactive when low-speed-on is 1. Otherwise it moves to active reduced speed if medium-speed-on is 1, or to active full speed if it is 0.
- R10: A wake event in a running mode has no effect, and a sleep request in a halted mode has no effect. When both arrive in a running mode, the sleep request is acted on.
- R11: With the default ratio encoding, the divide output is 8 for select 00, 4 for select 01, and 2 for select 10 or 11.
- R12: The mode changes only in a cycle that follows a sleep request or a wake event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep request |
| wake_evt | input | 1 | Wake event |
| stby_sel | input | 1 | Standby select |
| watch_en | input | 1 | Watch enable |
| low_spd_on | input | 1 | Low-speed (subactive) select |
| med_spd_on | input | 1 | Reduced active speed select |
| direct_xfer | input | 1 | Allow direct running-to-running transfers |
| sub_clk_sel | input | 2 | Subactive watch-clock divide select |
| mode_oh | output | NUM_MODES | One-hot current mode |
| sub_div | output | DIV_W | Selected subactive divide ratio |

## Verification
On every cycle, the assertions check the following. The mode vector stays one-hot. It holds still when there is neither a sleep request nor a wake. A wake in a running mode and a sleep request in a halted mode are both ignored. With direct transfer off, a sleep request in an active mode always lands in a halted mode. A wake with low-speed-on set lands in subactive. The divide output is 2 whenever the select's high bit is set. Only the bench's scenarios can show the following: the exact destination for each pattern of control bits, including each direct jump between running modes and the fallback when no pattern matches; the order of priority when a sleep request and a wake arrive together; and the full divide table.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   localparam int NUM_MODES = 7;
   localparam int M_ACT_HI  = 0;
   localparam int M_ACT_MED = 1;
   localparam int M_SUBACT  = 2;
   localparam int M_SLEEP   = 3;
   localparam int M_SUBSLP  = 4;
   localparam int M_WATCH   = 5;
   localparam int M_STANDBY = 6;
   localparam int FIRST_HALT = M_SLEEP;

   typedef struct packed {
      logic stby;
      logic watch;
      logic lowspd;
      logic medspd;
      logic direct;
   } lpm_ctrl_t;

   function automatic logic [NUM_MODES-1:0] mode_bit(input int idx);
      logic [NUM_MODES-1:0] v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/lpm_next_sel.sv
module lpm_next_sel
   import lpm_pkg::*;
(
   input  logic [NUM_MODES-1:0] cur,
   input  logic                 sleep_req,
   input  logic                 wake_evt,
   input  lpm_ctrl_t            ctrl,
   output logic [NUM_MODES-1:0] nxt
);
   logic                 halted;
   logic [NUM_MODES-1:0] halt_pick;
   logic [NUM_MODES-1:0] wake_pick;
   logic [NUM_MODES-1:0] dir_pick;
   logic                 dir_hit;

   assign halted = |cur[NUM_MODES-1:FIRST_HALT];

   always_comb begin
      if (cur[M_SUBACT])
         halt_pick = ctrl.stby ? mode_bit(M_WATCH) : mode_bit(M_SUBSLP);
      else if (!ctrl.stby)
         halt_pick = mode_bit(M_SLEEP);
      else
         halt_pick = ctrl.watch ? mode_bit(M_WATCH) : mode_bit(M_STANDBY);
   end

   always_comb begin
      if (ctrl.lowspd)
         wake_pick = mode_bit(M_SUBACT);
      else
         wake_pick = ctrl.medspd ? mode_bit(M_ACT_MED) : mode_bit(M_ACT_HI);
   end

   always_comb begin
      dir_hit  = 1'b0;
      dir_pick = cur;
      if (ctrl.direct) begin
         if (cur[M_ACT_HI]) begin
            if (!ctrl.stby && ctrl.medspd && !ctrl.lowspd) begin
               dir_hit = 1'b1; dir_pick = mode_bit(M_ACT_MED);
            end else if (ctrl.stby && ctrl.watch && ctrl.lowspd) begin
               dir_hit = 1'b1; dir_pick = mode_bit(M_SUBACT);
            end
         end else if (cur[M_ACT_MED]) begin
            if (!ctrl.stby && !ctrl.medspd && !ctrl.lowspd) begin
               dir_hit = 1'b1; dir_pick = mode_bit(M_ACT_HI);
            end else if (ctrl.stby && ctrl.watch && ctrl.lowspd) begin
               dir_hit = 1'b1; dir_pick = mode_bit(M_SUBACT);
            end
         end else if (cur[M_SUBACT]) begin
            if (ctrl.stby && ctrl.watch && !ctrl.lowspd) begin
               dir_hit  = 1'b1;
               dir_pick = ctrl.medspd ? mode_bit(M_ACT_MED) : mode_bit(M_ACT_HI);
            end
         end
      end
   end

   always_comb begin
      nxt = cur;
      if (halted) begin
         if (wake_evt) nxt = wake_pick;
      end else if (sleep_req) begin
         nxt = dir_hit ? dir_pick : halt_pick;
      end
   end
endmodule

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
   import lpm_pkg::*;
#(
   parameter int RESET_MODE = M_ACT_HI
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_MODES-1:0] nxt,
   output logic [NUM_MODES-1:0] cur
);
   if (RESET_MODE < 0 || RESET_MODE >= NUM_MODES) begin : g_bad_reset
      $error("lpm_mode_reg: RESET_MODE out of range");
   end

   for (genvar i = 0; i < NUM_MODES; i++) begin : g_bit
      localparam logic RST_VAL = (i == RESET_MODE);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cur[i] <= RST_VAL;
         else        cur[i] <= nxt[i];
      end
   end
endmodule

// File: rtl/lpm_sub_div.sv
module lpm_sub_div #(
   parameter int DIV_W      = 4,
   parameter bit RATIO_LOG2 = 1'b0
) (
   input  logic [1:0]       sel,
   output logic [DIV_W-1:0] div
);
   localparam int NEED_W = RATIO_LOG2 ? 2 : 4;

   if (DIV_W < NEED_W) begin : g_bad_width
      $error("lpm_sub_div: DIV_W too narrow for chosen encoding");
   end

   if (RATIO_LOG2) begin : g_log2
      always_comb begin
         if (sel[1])      div = DIV_W'(1);
         else if (sel[0]) div = DIV_W'(2);
         else             div = DIV_W'(3);
      end
   end else begin : g_ratio
      always_comb begin
         if (sel[1])      div = DIV_W'(2);
         else if (sel[0]) div = DIV_W'(4);
         else             div = DIV_W'(8);
      end
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import lpm_pkg::*;
#(
   parameter int DIV_W      = 4,
   parameter bit RATIO_LOG2 = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep_req,
   input  logic                 wake_evt,
   input  logic                 stby_sel,
   input  logic                 watch_en,
   input  logic                 low_spd_on,
   input  logic                 med_spd_on,
   input  logic                 direct_xfer,
   input  logic [1:0]           sub_clk_sel,
   output logic [NUM_MODES-1:0] mode_oh,
   output logic [DIV_W-1:0]     sub_div
);
   lpm_ctrl_t            ctrl;
   logic [NUM_MODES-1:0] nxt_mode;

   assign ctrl = '{stby: stby_sel, watch: watch_en, lowspd: low_spd_on,
                   medspd: med_spd_on, direct: direct_xfer};

   lpm_next_sel u_next (
      .cur       (mode_oh),
      .sleep_req (sleep_req),
      .wake_evt  (wake_evt),
      .ctrl      (ctrl),
      .nxt       (nxt_mode)
   );

   lpm_mode_reg #(.RESET_MODE(M_ACT_HI)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt   (nxt_mode),
      .cur   (mode_oh)
   );

   lpm_sub_div #(.DIV_W(DIV_W), .RATIO_LOG2(RATIO_LOG2)) u_div (
      .sel (sub_clk_sel),
      .div (sub_div)
   );
endmodule

// File: rtl/lpm_chk.sv
module lpm_chk
   import lpm_pkg::*;
#(
   parameter int DIV_W      = 4,
   parameter bit RATIO_LOG2 = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sleep_req,
   input logic                 wake_evt,
   input logic                 direct_xfer,
   input logic                 low_spd_on,
   input logic [1:0]           sub_clk_sel,
   input logic [NUM_MODES-1:0] mode_oh,
   input logic [DIV_W-1:0]     sub_div
);
   logic running, halted;
   assign running = |mode_oh[FIRST_HALT-1:0];
   assign halted  = |mode_oh[NUM_MODES-1:FIRST_HALT];

   p_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> mode_oh == mode_bit(M_ACT_HI));

   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_oh) == 1);

   p_halt_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && !direct_xfer && (mode_oh[M_ACT_HI] || mode_oh[M_ACT_MED])) |=> halted);

   p_wake_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && wake_evt && low_spd_on) |=> mode_oh[M_SUBACT]);

   p_run_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !sleep_req) |=> $stable(mode_oh));

   p_halt_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !wake_evt) |=> $stable(mode_oh));

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_req && !wake_evt) |=> $stable(mode_oh));

   p_div_fast_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sub_clk_sel[1] |-> sub_div == (RATIO_LOG2 ? DIV_W'(1) : DIV_W'(2)));
endmodule

bind pwr_mode_ctrl lpm_chk #(.DIV_W(DIV_W), .RATIO_LOG2(RATIO_LOG2)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_req   (sleep_req),
   .wake_evt    (wake_evt),
   .direct_xfer (direct_xfer),
   .low_spd_on  (low_spd_on),
   .sub_clk_sel (sub_clk_sel),
   .mode_oh     (mode_oh),
   .sub_div     (sub_div)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
   localparam int NM = 7;
   localparam int HI = 0, MED = 1, SUB = 2, SLP = 3, SSL = 4, WAT = 5, STB = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 0, wake_evt = 0, stby_sel = 0, watch_en = 0;
   logic low_spd_on = 0, med_spd_on = 0, direct_xfer = 0;
   logic [1:0] sub_clk_sel = 2'b00;
   logic [NM-1:0] mode_oh;
   logic [3:0] sub_div;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int exp_mode = HI;

   typedef struct { int mode; int due; string tag; } item_t;
   item_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwr_mode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
      .stby_sel(stby_sel), .watch_en(watch_en), .low_spd_on(low_spd_on),
      .med_spd_on(med_spd_on), .direct_xfer(direct_xfer),
      .sub_clk_sel(sub_clk_sel), .mode_oh(mode_oh), .sub_div(sub_div)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference model written from the requirements
   function automatic int model(input int m, input bit sl, wk, ss, we, ls, ms, dt);
      bit halted = (m >= SLP);
      if (halted) return wk ? (ls ? SUB : (ms ? MED : HI)) : m;
      if (!sl) return m;
      if (dt) begin
         if (m == HI && !ss && ms && !ls) return MED;
         if (m == HI && ss && we && ls)   return SUB;
         if (m == MED && !ss && !ms && !ls) return HI;
         if (m == MED && ss && we && ls)    return SUB;
         if (m == SUB && ss && we && !ls)   return ms ? MED : HI;
      end
      if (m == SUB) return ss ? WAT : SSL;
      if (!ss) return SLP;
      return we ? WAT : STB;
   endfunction

   task automatic step(input bit sl, wk, ss, we, ls, ms, dt, input string tag);
      item_t it;
      @(negedge clk);
      sleep_req = sl; wake_evt = wk; stby_sel = ss; watch_en = we;
      low_spd_on = ls; med_spd_on = ms; direct_xfer = dt;
      exp_mode = model(exp_mode, sl, wk, ss, we, ls, ms, dt);
      it.mode = exp_mode; it.due = cyc + 1; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: compares each expected item in the cycle it becomes due
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due == cyc) begin
         item_t it;
         it = q.pop_front();
         check(mode_oh == (NM'(1) << it.mode), it.tag, int'(mode_oh), 1 << it.mode);
         check($countones(mode_oh) == 1, "R2 onehot", int'(mode_oh), 1 << it.mode);
      end
   end

   task automatic div_chk(input logic [1:0] s, input int exp);
      @(negedge clk);
      sub_clk_sel = s;
      #1;
      check(sub_div == 4'(exp), "R11 divide", int'(sub_div), exp);
   endtask

   initial begin
      #300000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(mode_oh == NM'(1), "R1 in reset", int'(mode_oh), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(mode_oh == NM'(1), "R1 after reset", int'(mode_oh), 1);
      // sl wk ss we ls ms dt
      step(0,0,0,0,0,0,0, "R12 idle");
      step(0,1,0,0,0,1,0, "R10 wake while running");
      step(1,0,0,0,0,0,0, "R3 to sleep");
      step(1,0,1,1,1,0,0, "R10 sleep while halted");
      step(0,1,0,0,0,0,0, "R9 wake to full");
      step(1,0,1,0,0,0,0, "R3 to standby");
      step(0,0,1,0,0,0,0, "R12 hold standby");
      step(0,1,0,0,0,1,0, "R9 wake to reduced");
      step(1,0,1,1,0,1,0, "R3 reduced to watch");
      step(0,1,0,0,1,0,0, "R9 wake to subactive");
      step(1,0,0,0,1,0,0, "R4 to subsleep");
      step(0,1,0,0,1,0,0, "R9 back to subactive");
      step(1,0,1,0,1,0,0, "R4 to watch");
      step(0,1,0,0,1,0,0, "R9 back to subactive");
      step(1,0,1,1,0,1,1, "R7 sub to reduced");
      step(1,0,0,0,0,0,1, "R6 reduced to full");
      step(1,0,0,0,0,1,1, "R5 full to reduced");
      step(1,0,1,1,1,0,1, "R6 reduced to sub");
      step(1,0,1,1,0,0,1, "R7 sub to full");
      step(1,0,1,1,1,0,1, "R5 full to sub");
      step(1,0,0,0,0,0,1, "R8 sub fallback subsleep");
      step(0,1,0,0,0,0,0, "R9 wake to full");
      step(1,0,1,0,1,0,1, "R8 full fallback standby");
      step(0,1,0,0,0,0,0, "R9 wake to full");
      step(1,0,0,0,0,0,1, "R8 full fallback sleep");
      step(0,1,0,0,0,0,0, "R9 wake to full");
      step(1,1,0,0,0,0,0, "R10 sleep wins over wake");
      step(0,1,0,0,0,0,0, "R9 wake to full");
      step(0,0,0,0,0,0,0, "R12 idle");
      @(negedge clk);
      @(negedge clk);
      check(q.size() == 0, "R12 scoreboard drained", q.size(), 0);
      div_chk(2'b00, 8);
      div_chk(2'b01, 4);
      div_chk(2'b10, 2);
      div_chk(2'b11, 2);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule